// File: doc/BRIEF.md
# Wave-Memory / Register-Space DMA Engine

This block moves 32-bit words between a wave-sample memory and the chip's register space without processor help, or clears a run of words in either one. Software programs three configuration words: a memory address made of a high and a low field, a register word index, and a control word with the length, direction, clear bit and start bit. Writing the control word with the start bit set launches the transfer. The engine then drives two master ports, one to the memory and one to the register bus. Each port carries one word per handshake. When the run ends, a one-cycle end event goes to both interrupt paths and the busy flag drops.

Memory byte addresses are built as `(hi << 16) | (lo << 2)` and then cut to the memory size. A run that touches memory is shortened to the words left before the top of memory. Each word passes through a request/ready handshake on its port. A read returns its data on a separate response strobe in a later cycle.

The sequencer has six states:
- `ST_IDLE`: waits for the start bit.
- `ST_LOAD`: latches the start addresses and the clipped count.
- `ST_READ`: issues the source read.
- `ST_RWAIT`: waits for the read data.
- `ST_WRITE`: issues the destination write.
- `ST_DONE`: raises the end event for one cycle.

Transitions:
- IDLE→LOAD when started.
- LOAD→DONE for a zero count, LOAD→WRITE in clear mode, otherwise LOAD→READ.
- READ→RWAIT when the request is accepted.
- RWAIT→WRITE when the data returns.
- WRITE→READ, or WRITE→WRITE in clear mode, while words remain.
- WRITE→DONE after the last word.
- DONE→IDLE.

Top module: `wavedma_engine`

## Requirements
- R1: Only a write with `cfg_sel`=2 and bit 31 (start) set launches a transfer, and `busy` is 1 from the next cycle. A control write with bit 31 clear moves nothing, and both ports stay idle while `busy` is 0.
- R2: Configuration word `cfg_sel`=0 holds lo in bits [13:0] and hi in bits [22:16]. The first memory byte address is `((hi<<16)|(lo<<2))` masked to MEM_AW bits.
- R3: Word `cfg_sel`=1 holds the register word index in bits [13:0]. The first register byte address is that index times 4. Both addresses step by 4 after each word written.
- R4: Control bit 16 (direction) = 1 with bit 17 (clear) = 0 copies registers to memory. Each word is read on the register port and then written to memory.
- R5: Direction 0 with clear 0 copies memory to registers. Each word is read on the memory port and then written to the register port.
- R6: The word count in control bits [14:0] is cut to the words remaining before the end of memory for every run that touches memory.
- R7: Clear 1 with direction 1 writes zeros to memory for the (clipped) count and issues no reads on either port.
- R8: Clear 1 with direction 0 writes zeros to registers for the full count. This run is not clipped by the memory size and does not touch memory.
- R9: After the last word, `dma_end_main` and `dma_end_sub` pulse high together for exactly one cycle, and `busy` clears on the next cycle.
- R10: A count of zero issues no port traffic, yet still raises one end pulse and clears `busy`.
- R11: Configuration writes of any kind made while `busy` is 1 are ignored. They change neither the running transfer nor the fields used by later transfers.
- R12: A port request held without ready keeps its valid, address and write flag unchanged. Under stalls, each word is moved exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0 memory address, 1 register index, 2 control) |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Start bit / transfer in progress |
| dma_end_main | output | 1 | End event to the main-processor interrupt path |
| dma_end_sub | output | 1 | End event to the sound-processor interrupt path |
| mem_valid | output | 1 | Memory port request |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data strobe |
| mem_rdata | input | 32 | Memory read data |
| reg_valid | output | 1 | Register port request |
| reg_ready | input | 1 | Register port accepts the request |
| reg_we | output | 1 | Register request is a write |
| reg_addr | output | REG_AW | Register byte address |
| reg_wdata | output | 32 | Register write data |
| reg_rvalid | input | 1 | Register read data strobe |
| reg_rdata | input | 32 | Register read data |

## Verification
A wrong next-state choice shows at the ports within one or two handshakes, in one of three ways: a read where a clear run should only write, a write on the wrong port, or an extra or missing word in the destination arrays. A mis-latched count or start address becomes visible at the first or last address the port presents. This also covers clipping near the top of memory. A bad start-bit or end-pulse path shows up in the busy flag and the end-pulse counters. The bench compares the final contents of both arrays and counts the handshakes in each run.

// File: rtl/wavedma_pkg.sv
package wavedma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READ,
        ST_RWAIT,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic dir;   // 1: registers -> memory, 0: memory -> registers
        logic gate;  // 1: write zeros, no reads
    } xfer_mode_t;

    localparam logic [1:0] SEL_MEMADR = 2'd0;
    localparam logic [1:0] SEL_REGADR = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    localparam int HI_LSB    = 16;
    localparam int DIR_BIT   = 16;
    localparam int GATE_BIT  = 17;
    localparam int START_BIT = 31;
endpackage

// File: rtl/wavedma_cfg.sv
module wavedma_cfg
    import wavedma_pkg::*;
#(
    parameter int HI_W  = 7,
    parameter int LO_W  = 14,
    parameter int RF_W  = 14,
    parameter int LEN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              done,
    output logic [HI_W-1:0]   hi_q,
    output logic [LO_W-1:0]   lo_q,
    output logic [RF_W-1:0]   rf_q,
    output logic [LEN_W-1:0]  len_q,
    output xfer_mode_t        mode_q,
    output logic              start_q
);
    logic cfg_unused;
    assign cfg_unused = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            rf_q    <= '0;
            len_q   <= '0;
            mode_q  <= '0;
            start_q <= 1'b0;
        end else if (done) begin
            start_q <= 1'b0;
        end else if (cfg_we && !start_q) begin
            case (cfg_sel)
                SEL_MEMADR: begin
                    lo_q <= cfg_wdata[LO_W-1:0];
                    hi_q <= cfg_wdata[HI_LSB +: HI_W];
                end
                SEL_REGADR: rf_q <= cfg_wdata[RF_W-1:0];
                SEL_CTRL: begin
                    len_q       <= cfg_wdata[LEN_W-1:0];
                    mode_q.dir  <= cfg_wdata[DIR_BIT];
                    mode_q.gate <= cfg_wdata[GATE_BIT];
                    start_q     <= cfg_wdata[START_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wavedma_addr.sv
module wavedma_addr
    import wavedma_pkg::*;
#(
    parameter int MEM_AW = 17,
    parameter int REG_AW = 16,
    parameter int HI_W   = 7,
    parameter int LO_W   = 14,
    parameter int LEN_W  = 15,
    parameter int CNT_W  = 16
) (
    input  logic [HI_W-1:0]      hi,
    input  logic [LO_W-1:0]      lo,
    input  logic [REG_AW-3:0]    rf,
    input  logic [LEN_W-1:0]     len,
    input  xfer_mode_t           mode,
    output logic [MEM_AW-1:0]    mem_start,
    output logic [REG_AW-1:0]    reg_start,
    output logic [CNT_W-1:0]     clip_len
);
    localparam int RAW_W = HI_LSB + HI_W;

    logic [RAW_W-1:0]  raw_addr;
    logic [CNT_W-1:0]  words_left;
    logic [CNT_W-1:0]  len_ext;

    always_comb begin
        raw_addr   = {hi, {HI_LSB{1'b0}}} | RAW_W'({lo, 2'b00});
        mem_start  = raw_addr[MEM_AW-1:0];
        reg_start  = {rf, 2'b00};
        words_left = (CNT_W'(1) << (MEM_AW - 2)) - CNT_W'(mem_start[MEM_AW-1:2]);
        len_ext    = CNT_W'(len);
        if (mode.gate && !mode.dir)
            clip_len = len_ext;
        else if (len_ext < words_left)
            clip_len = len_ext;
        else
            clip_len = words_left;
    end
endmodule

// File: rtl/wavedma_seq.sv
module wavedma_seq
    import wavedma_pkg::*;
#(
    parameter int MEM_AW = 17,
    parameter int REG_AW = 16,
    parameter int CNT_W  = 16,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_q,
    input  xfer_mode_t        mode,
    input  logic [MEM_AW-1:0] mem_start,
    input  logic [REG_AW-1:0] reg_start,
    input  logic [CNT_W-1:0]  clip_len,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              reg_ready,
    input  logic              reg_rvalid,
    input  logic [DW-1:0]     reg_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              reg_valid,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              done
);
    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [MEM_AW-1:0] maddr_q;
    logic [REG_AW-1:0] raddr_q;
    logic [DW-1:0]     data_q;
    logic              src_ready, src_rvalid, dst_ready;
    logic              last_word;

    assign src_ready  = mode.dir ? reg_ready  : mem_ready;
    assign src_rvalid = mode.dir ? reg_rvalid : mem_rvalid;
    assign dst_ready  = mode.dir ? mem_ready  : reg_ready;
    assign last_word  = (cnt_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_q) state_d = ST_LOAD;
            ST_LOAD: begin
                if (clip_len == '0)  state_d = ST_DONE;
                else if (mode.gate)  state_d = ST_WRITE;
                else                 state_d = ST_READ;
            end
            ST_READ:  if (src_ready)  state_d = ST_RWAIT;
            ST_RWAIT: if (src_rvalid) state_d = ST_WRITE;
            ST_WRITE: begin
                if (dst_ready) begin
                    if (last_word)      state_d = ST_DONE;
                    else if (mode.gate) state_d = ST_WRITE;
                    else                state_d = ST_READ;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // word counter, address pointers, data holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            maddr_q <= '0;
            raddr_q <= '0;
            data_q  <= '0;
        end else begin
            if (state_q == ST_LOAD) begin
                cnt_q   <= clip_len;
                maddr_q <= mem_start;
                raddr_q <= reg_start;
            end
            if (state_q == ST_RWAIT && src_rvalid)
                data_q <= mode.dir ? reg_rdata : mem_rdata;
            if (state_q == ST_WRITE && dst_ready) begin
                cnt_q   <= cnt_q - CNT_W'(1);
                maddr_q <= maddr_q + MEM_AW'(4);
                raddr_q <= raddr_q + REG_AW'(4);
            end
        end
    end

    // outputs
    always_comb begin
        mem_valid = ((state_q == ST_READ) && !mode.dir) || ((state_q == ST_WRITE) && mode.dir);
        reg_valid = ((state_q == ST_READ) && mode.dir)  || ((state_q == ST_WRITE) && !mode.dir);
        mem_we    = (state_q == ST_WRITE);
        reg_we    = (state_q == ST_WRITE);
        mem_addr  = maddr_q;
        reg_addr  = raddr_q;
        mem_wdata = mode.gate ? '0 : data_q;
        reg_wdata = mode.gate ? '0 : data_q;
        done      = (state_q == ST_DONE);
    end
endmodule

// File: rtl/wavedma_engine.sv
module wavedma_engine
    import wavedma_pkg::*;
#(
    parameter int MEM_AW = 17,
    parameter int REG_AW = 16,
    parameter int HI_W   = 7,
    parameter int LO_W   = 14,
    parameter int LEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              busy,
    output logic              dma_end_main,
    output logic              dma_end_sub,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              reg_valid,
    input  logic              reg_ready,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_rvalid,
    input  logic [31:0]       reg_rdata
);
    localparam int RF_W  = REG_AW - 2;
    localparam int CNT_W = (LEN_W > MEM_AW - 1) ? LEN_W + 1 : MEM_AW;

    logic [HI_W-1:0]   hi_q;
    logic [LO_W-1:0]   lo_q;
    logic [RF_W-1:0]   rf_q;
    logic [LEN_W-1:0]  len_q;
    xfer_mode_t        mode_q;
    logic              start_q;
    logic              done;
    logic [MEM_AW-1:0] mem_start;
    logic [REG_AW-1:0] reg_start;
    logic [CNT_W-1:0]  clip_len;

    wavedma_cfg #(.HI_W(HI_W), .LO_W(LO_W), .RF_W(RF_W), .LEN_W(LEN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .done(done), .hi_q(hi_q), .lo_q(lo_q),
        .rf_q(rf_q), .len_q(len_q), .mode_q(mode_q), .start_q(start_q)
    );

    wavedma_addr #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .HI_W(HI_W), .LO_W(LO_W),
                   .LEN_W(LEN_W), .CNT_W(CNT_W)) u_addr (
        .hi(hi_q), .lo(lo_q), .rf(rf_q), .len(len_q), .mode(mode_q),
        .mem_start(mem_start), .reg_start(reg_start), .clip_len(clip_len)
    );

    wavedma_seq #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .CNT_W(CNT_W), .DW(32)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .mode(mode_q),
        .mem_start(mem_start), .reg_start(reg_start), .clip_len(clip_len),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .done(done)
    );

    assign busy         = start_q;
    assign dma_end_main = done;
    assign dma_end_sub  = done;
endmodule

// File: rtl/wavedma_engine_chk.sv
module wavedma_engine_chk #(
    parameter int MEM_AW = 17,
    parameter int REG_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              end_main,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              reg_valid,
    input logic              reg_ready,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    // R12
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_we));

    // R9
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_main |=> !end_main && !busy);

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(end_main));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid && !reg_valid);

    // R4
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && reg_valid));
endmodule

bind wavedma_engine wavedma_engine_chk #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .end_main(dma_end_main),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/wavedma_engine_test.sv
module wavedma_engine_test;
    localparam int MEM_AW = 17;
    localparam int REG_AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [31:0]       cfg_wdata = '0;
    logic              busy, dma_end_main, dma_end_sub;
    logic              mem_valid, mem_we, reg_valid, reg_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [REG_AW-1:0] reg_addr;
    logic [31:0]       mem_wdata, reg_wdata;
    logic              mem_ready = 1'b1, reg_ready = 1'b1;
    logic              mem_rvalid = 1'b0, reg_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0, reg_rdata = '0;

    wavedma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .dma_end_main(dma_end_main), .dma_end_sub(dma_end_sub),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int unsigned cyc = 0;
    logic stall_en = 1'b0;
    logic [31:0] mem_m [int unsigned];
    logic [31:0] reg_m [int unsigned];
    int mem_rd_n, mem_wr_n, reg_rd_n, reg_wr_n, endm_n, ends_n;

    function automatic logic [31:0] mem_val(input int unsigned a);
        return mem_m.exists(a) ? mem_m[a] : (32'h5A00_0000 | a);
    endfunction
    function automatic logic [31:0] reg_val(input int unsigned a);
        return reg_m.exists(a) ? reg_m[a] : (32'hC300_0000 | a);
    endfunction

    // memory and register-bus responders
    always @(posedge clk) begin
        cyc        <= cyc + 1;
        mem_ready  <= !stall_en || (cyc % 3 != 1);
        reg_ready  <= !stall_en || (cyc % 4 != 2);
        mem_rvalid <= 1'b0;
        reg_rvalid <= 1'b0;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin mem_m[int'(mem_addr)] = mem_wdata; mem_wr_n++; end
            else begin mem_rvalid <= 1'b1; mem_rdata <= mem_val(int'(mem_addr)); mem_rd_n++; end
        end
        if (reg_valid && reg_ready) begin
            if (reg_we) begin reg_m[int'(reg_addr)] = reg_wdata; reg_wr_n++; end
            else begin reg_rvalid <= 1'b1; reg_rdata <= reg_val(int'(reg_addr)); reg_rd_n++; end
        end
        if (dma_end_main) endm_n++;
        if (dma_end_sub)  ends_n++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] w_mem(input int hi, input int lo);
        return {9'b0, 7'(hi), 2'b00, 14'(lo)};
    endfunction
    function automatic logic [31:0] w_reg(input int rf);
        return {18'b0, 14'(rf)};
    endfunction
    function automatic logic [31:0] w_ctl(input int len, input bit dir, input bit gate, input bit go);
        return {go, 13'b0, gate, dir, 1'b0, 15'(len)};
    endfunction

    task automatic clear_all();
        mem_m.delete(); reg_m.delete();
        mem_rd_n = 0; mem_wr_n = 0; reg_rd_n = 0; reg_wr_n = 0; endm_n = 0; ends_n = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        chk({req, " busy cleared"}, 32'(busy), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset end", {dma_end_main, dma_end_sub}, 0);
        chk("R1 reset ports idle", {mem_valid, reg_valid}, 0);
    endtask

    task automatic t_no_start();
        clear_all();
        cfg_write(2'd2, w_ctl(3, 1'b1, 1'b0, 1'b0));
        repeat (10) @(negedge clk);
        chk("R1 no start busy", 32'(busy), 0);
        chk("R1 no start traffic", mem_rd_n + mem_wr_n + reg_rd_n + reg_wr_n + endm_n, 0);
    endtask

    task automatic t_copy_r2m();
        clear_all();
        cfg_write(2'd0, w_mem(3, 'h10));   // 0x30040 masked -> 0x10040
        cfg_write(2'd1, w_reg('h20));      // 0x80
        cfg_write(2'd2, w_ctl(5, 1'b1, 1'b0, 1'b1));
        chk("R1 busy after start", 32'(busy), 1);
        wait_idle("R4");
        for (int i = 0; i < 5; i++)
            chk("R2 R3 R4 mem word", mem_val('h10040 + 4*i), 32'hC300_0000 | ('h80 + 4*i));
        chk("R4 reg reads", reg_rd_n, 5);
        chk("R4 mem writes", mem_wr_n, 5);
        chk("R4 no mem reads", mem_rd_n + reg_wr_n, 0);
        chk("R9 end main once", endm_n, 1);
        chk("R9 end sub once", ends_n, 1);
    endtask

    task automatic t_copy_m2r();
        clear_all();
        for (int i = 0; i < 4; i++) mem_m['h200 + 4*i] = 32'h1111_0000 + i;
        stall_en = 1'b1;
        cfg_write(2'd0, w_mem(0, 'h80));   // 0x200
        cfg_write(2'd1, w_reg('h100));     // 0x400
        cfg_write(2'd2, w_ctl(4, 1'b0, 1'b0, 1'b1));
        wait_idle("R5");
        stall_en = 1'b0;
        for (int i = 0; i < 4; i++)
            chk("R5 R12 reg word", reg_val('h400 + 4*i), 32'h1111_0000 + i);
        chk("R5 no write past end", 32'(reg_m.exists('h410)), 0);
        chk("R12 mem reads under stall", mem_rd_n, 4);
        chk("R12 reg writes under stall", reg_wr_n, 4);
    endtask

    task automatic t_clip();
        clear_all();
        cfg_write(2'd0, w_mem(1, 'h3FFC)); // 0x1FFF0, 4 words to the top
        cfg_write(2'd1, w_reg(0));
        cfg_write(2'd2, w_ctl(10, 1'b1, 1'b0, 1'b1));
        wait_idle("R6");
        chk("R6 clipped writes", mem_wr_n, 4);
        chk("R6 clipped reads", reg_rd_n, 4);
        chk("R6 last word", mem_val('h1FFFC), 32'hC300_000C);
    endtask

    task automatic t_gate_mem();
        clear_all();
        for (int i = 0; i < 4; i++) mem_m['h100 + 4*i] = 32'hFFFF_0000 + i;
        cfg_write(2'd0, w_mem(0, 'h40));   // 0x100
        cfg_write(2'd2, w_ctl(3, 1'b1, 1'b1, 1'b1));
        wait_idle("R7");
        for (int i = 0; i < 3; i++) chk("R7 zeroed", mem_val('h100 + 4*i), 0);
        chk("R7 word after run kept", mem_val('h10C), 32'hFFFF_0003);
        chk("R7 no reads", mem_rd_n + reg_rd_n + reg_wr_n, 0);
    endtask

    task automatic t_gate_reg();
        clear_all();
        cfg_write(2'd0, w_mem(1, 'h3FFC)); // would clip to 4
        cfg_write(2'd1, w_reg('h40));      // 0x100
        cfg_write(2'd2, w_ctl(6, 1'b0, 1'b1, 1'b1));
        wait_idle("R8");
        chk("R8 unclipped count", reg_wr_n, 6);
        for (int i = 0; i < 6; i++) chk("R8 reg zeroed", reg_val('h100 + 4*i), 0);
        chk("R8 no memory or reads", mem_rd_n + mem_wr_n + reg_rd_n, 0);
    endtask

    task automatic t_zero_len();
        clear_all();
        cfg_write(2'd2, w_ctl(0, 1'b1, 1'b0, 1'b1));
        wait_idle("R10");
        chk("R10 no traffic", mem_rd_n + mem_wr_n + reg_rd_n + reg_wr_n, 0);
        chk("R10 end pulse", endm_n + ends_n, 2);
    endtask

    task automatic t_busy_ignore();
        clear_all();
        stall_en = 1'b1;
        cfg_write(2'd0, w_mem(0, 'h100));  // 0x400
        cfg_write(2'd1, w_reg('h10));      // 0x40
        cfg_write(2'd2, w_ctl(6, 1'b1, 1'b0, 1'b1));
        cfg_write(2'd0, w_mem(0, 'h300));  // ignored
        cfg_write(2'd2, w_ctl(2, 1'b0, 1'b1, 1'b1)); // ignored
        wait_idle("R11");
        stall_en = 1'b0;
        chk("R11 count kept", mem_wr_n, 6);
        chk("R11 single end", endm_n, 1);
        chk("R11 last addr kept", mem_val('h414), 32'hC300_0054);
        mem_m.delete(); mem_wr_n = 0;
        cfg_write(2'd2, w_ctl(1, 1'b1, 1'b0, 1'b1));
        wait_idle("R11");
        chk("R11 old address reused", 32'(mem_m.exists('h400)), 1);
        chk("R11 ignored address unused", 32'(mem_m.exists('hC00)), 0);
        chk("R11 relaunch count", mem_wr_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_start();
        t_copy_r2m();
        t_copy_m2r();
        t_clip();
        t_gate_mem();
        t_gate_reg();
        t_zero_len();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule